// File: doc/BRIEF.md
# Two-bit burst address sequencer

This block keeps a registered address and steps its two least significant bits through a four-word burst. A burst starts when either of two start strobes is high at a clock edge. The full external address is then captured. On each later edge where advance is high and neither strobe is high, the low two bits move to the next position in the burst. The upper bits are never touched.

The order within a burst is set by a level input. Low selects linear order: the low bits count up modulo four from the loaded value. High selects interleaved order: the low bits are the loaded low bits XOR a two-bit count of advances. A board that leaves the input floating should pull it high, so interleaved is the default.

The output address is a register. Mode is consulted only when a step is computed. Changing mode in the middle of a burst therefore alters the next address produced, not the one already showing.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is active and after its release with no strobe, `addr_o` is all zeros.
- R2: A high on `start_a_i` or `start_b_i` at a clock edge makes `addr_o` equal `addr_i` after that edge and clears the advance count to zero.
- R3: With `mode_i` low (linear) at an advancing edge, the low two bits become (loaded low bits + advance count) mod 4, e.g. loaded 01 gives 01,10,11,00.
- R4: With `mode_i` high (interleaved) at an advancing edge, the low two bits become loaded low bits XOR advance count, e.g. loaded 10 gives 10,11,00,01.
- R5: An edge with `adv_i` low and no strobe leaves `addr_o` unchanged.
- R6: When a strobe and `adv_i` are high at the same edge, the load wins and no step is taken.
- R7: Bits above the low two change only on a load; the fifth address of a burst returns to the first one, with no carry upward.
- R8: A change of `mode_i` alters no output by itself; it only selects the rule for the next advancing edge, which still uses the count of advances since the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_a_i | input | 1 | Burst start strobe, first source |
| start_b_i | input | 1 | Burst start strobe, second source |
| adv_i | input | 1 | Step to the next burst address |
| mode_i | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_i | input | ADDR_W | External address captured on a start |
| addr_o | output | ADDR_W | Current registered address |

## Verification
Every result in this block appears one edge after the stimulus that causes it. A load, a step and a hold are all visible just after the rising edge at which the inputs were sampled. The bench changes inputs on the falling edge and checks `addr_o` at the next falling edge. Each check therefore sees the effect of exactly one rising edge, and a model in the bench has applied the same edge before comparing. The sweep covers both orders and every starting low value. It also covers both strobes and runs bursts past the fourth address.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned LOW_W = 2;
  typedef logic [LOW_W-1:0] low_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} order_e;
endpackage

// File: rtl/burst_cnt.sv
module burst_cnt
  import burst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output low_t cnt_o,
  output low_t cnt_next_o
);
  low_t cnt_q;

  // natural 2-bit wrap gives the 4-word boundary
  assign cnt_next_o = cnt_q + low_t'(1);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_next_o;
  end

  assert_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/burst_order.sv
module burst_order
  import burst_pkg::*;
(
  input  order_e order_i,
  input  low_t   base_i,
  input  low_t   cnt_i,
  output low_t   low_o
);
  low_t lin_w, intl_w;

  assign lin_w  = base_i + cnt_i;
  assign intl_w = base_i ^ cnt_i;
  assign low_o  = (order_i == ORD_INTERLEAVE) ? intl_w : lin_w;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_a_i,
  input  logic              start_b_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - LOW_W;

  logic            load_w, step_w;
  logic [HI_W-1:0] hi_q;
  low_t            base_lo_q, cur_lo_q;
  low_t            cnt_w, cnt_next_w, step_lo_w;
  order_e          order_w;

  assign load_w  = start_a_i | start_b_i;
  assign step_w  = adv_i & ~load_w;
  assign order_w = order_e'(mode_i);

  burst_cnt i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (load_w),
    .inc_i      (step_w),
    .cnt_o      (cnt_w),
    .cnt_next_o (cnt_next_w)
  );

  burst_order i_order (
    .order_i (order_w),
    .base_i  (base_lo_q),
    .cnt_i   (cnt_next_w),
    .low_o   (step_lo_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q      <= '0;
      base_lo_q <= '0;
      cur_lo_q  <= '0;
    end else if (load_w) begin
      hi_q      <= addr_i[ADDR_W-1:LOW_W];
      base_lo_q <= addr_i[LOW_W-1:0];
      cur_lo_q  <= addr_i[LOW_W-1:0];
    end else if (step_w) begin
      cur_lo_q  <= step_lo_w;
    end
  end

  assign addr_o = {hi_q, cur_lo_q};

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_a_i || start_b_i) |=> addr_o == $past(addr_i));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_a_i && !start_b_i && !adv_i) |=> $stable(addr_o));

  assert_upper_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_a_i && !start_b_i) |=> $stable(addr_o[ADDR_W-1:LOW_W]));

  assert_lin_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !start_a_i && !start_b_i && !mode_i)
      |=> addr_o[LOW_W-1:0] == low_t'(base_lo_q + cnt_w));

  // interleaved steps always flip bit 0
  assert_intl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !start_a_i && !start_b_i && mode_i)
      |=> addr_o[0] != $past(addr_o[0]));

  assert_prio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && (start_a_i || start_b_i)) |=> cnt_w == '0);
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int unsigned ADDR_W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_a, start_b, adv, mode;
  logic [ADDR_W-1:0] addr_in, addr_out;

  int checks = 0, errors = 0, cycles = 0;
  logic [ADDR_W-1:0] exp_addr;
  logic [ADDR_W-1:0] m_base;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) i_burst_addr_gen (
    .clk_i(clk), .rst_ni(rst_ni), .start_a_i(start_a), .start_b_i(start_b),
    .adv_i(adv), .mode_i(mode), .addr_i(addr_in), .addr_o(addr_out)
  );

  task automatic check(string req);
    checks++;
    if (addr_out !== exp_addr) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, addr_out, exp_addr);
    end
  endtask

  // drive at negedge, let one posedge pass, update model, check at next negedge
  task automatic cyc(logic a, logic b, logic v, logic m, logic [ADDR_W-1:0] ad, string req);
    start_a = a; start_b = b; adv = v; mode = m; addr_in = ad;
    @(negedge clk);
    if (a || b) begin
      m_base = ad; m_cnt = 0;
    end else if (v) begin
      m_cnt = (m_cnt + 1) % 4;
      exp_addr[1:0] = m ? (m_base[1:0] ^ 2'(m_cnt)) : 2'((m_base[1:0] + m_cnt) % 4);
    end
    if (a || b) exp_addr = ad;
    check(req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected <100000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    start_a = 0; start_b = 0; adv = 0; mode = 1; addr_in = '0;
    exp_addr = '0; m_base = '0;
    @(negedge clk); check("R1");
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); check("R1");
    cyc(0, 0, 0, 1, 8'hFF, "R1");

    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int src = 0; src < 2; src++) begin
          logic [ADDR_W-1:0] ad;
          ad = {6'(8'h2D + s * 7 + src * 19 + m * 3), 2'(s)};
          cyc(src == 0, src == 1, 0, m[0], ad, "R2");
          for (int k = 0; k < 6; k++) begin
            cyc(0, 0, 1, m[0], ~ad, m ? "R4 R7" : "R3 R7");
            cyc(0, 0, 0, m[0], ~ad, "R5");
          end
        end

    // load beats advance
    cyc(1, 0, 0, 0, 8'h42, "R2");
    cyc(0, 0, 1, 0, 8'h00, "R3");
    cyc(0, 1, 1, 0, 8'h9B, "R6");
    cyc(1, 1, 1, 1, 8'hC7, "R6");
    cyc(0, 0, 1, 1, 8'h00, "R4");

    // mode change mid-burst
    cyc(1, 0, 0, 1, 8'h71, "R2");
    cyc(0, 0, 1, 1, 8'h00, "R8");
    cyc(0, 0, 1, 1, 8'h00, "R8");
    cyc(0, 0, 0, 0, 8'h00, "R8");
    cyc(0, 0, 1, 0, 8'h00, "R8");
    cyc(0, 0, 0, 1, 8'h00, "R8");
    cyc(0, 0, 1, 1, 8'h00, "R8");

    // upper bits all ones: wrap must not carry
    cyc(0, 1, 0, 0, 8'hFF, "R7");
    for (int k = 0; k < 5; k++) cyc(0, 0, 1, 0, 8'h00, "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule